// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

The controller gathers 32 interrupt request lines into a single processor interrupt. A source mask selects which lines take part. A bank of prioritised vector slots tells the processor where to go. Each slot holds a source number, a slot enable and a handler address, and slot 0 outranks slot 1 and every slot after it. When an enabled request is active, the controller raises its interrupt output. The vector register then holds the handler address of the best active slot. An enabled source that no slot claims is served through a default handler address, at a level below every slot.

Software reads the vector register to enter a handler, and that read marks the winning level as in service. While a level is in service, only a slot of strictly higher priority can raise the interrupt again or change the vector, so handlers nest. Writing any value to the vector register at the end of a handler acknowledges it and releases the most recently entered level. Any lower request still pending then gets through.

All registers sit on a simple word-addressed bus. Writes take effect at the clock edge. Read data follows the address combinationally. The interrupt output and the vector register are both registered, so they change one cycle after the inputs that cause them.

Top module: `vpic_top`

## Requirements
- R1: After reset, irq_o is 0 and every register reads 0: the source mask, the default vector, the vector register, and each slot control and slot address register. No level is in service.
- R2: A request on source n is ignored unless bit n of the source mask (address 0x00) is set. irq_o rises one cycle after an enabled request becomes active while nothing is in service, and with no enabled request irq_o is 0.
- R3: Slot i has a control register at 0x10+i, with bit 5 as the slot enable and bits 4:0 as the source number, and a handler address register at 0x20+i. Both read back as written, and bits 31:6 of a control register read 0.
- R4: The vector register (0x02) shows the handler address of the lowest-numbered enabled slot whose source is enabled and requesting. It updates one cycle after the requests change.
- R5: If several enabled slots name the same source, the lowest-numbered of them wins.
- R6: An enabled, requesting source that no enabled slot names raises irq_o. When no slot is active, it puts the default vector (address 0x01) in the vector register, at a priority below all slots.
- R7: A slot whose bit 5 is 0 matches nothing, and its source counts as unassigned.
- R8: A read of the vector register while irq_o is 1 marks the level shown as in service. The interrupt then drops on the next cycle unless a higher-priority request is active.
- R9: While a level is in service, requests of the same or lower priority leave irq_o at 0 and the vector register unchanged. A slot of strictly higher priority raises irq_o and replaces the vector.
- R10: Writing any value to the vector register releases the most recently entered level. A pending request that now outranks every remaining in-service level raises irq_o on the next cycle.
- R11: A read of the vector register while irq_o is 0 enters no level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 32 | Interrupt request lines, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (marks handler entry on the vector register) |
| addr | input | 6 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr |
| irq_o | output | 1 | Processor interrupt request |

## Verification
The bench programs two slots with the same source to check that the lower slot wins. It then disables that slot, which shows whether a design looks at bit 5 or simply matches on the source field. It raises an unclaimed source to catch a controller that drops such requests or ranks the default vector above a slot. The nesting sequence enters a mid-priority handler and then raises a lower and a higher request: a design without a service level would re-raise at once, and one that pops the wrong level would let the lower request in after the first acknowledge. It also reads the vector with irq_o low and acknowledges with nothing in service, which would corrupt the level stack of a design that does not guard those cases.

// File: rtl/vpic_pkg.sv
package vpic_pkg;

    localparam int SRC_NUM = 32;
    localparam int SRC_W   = $clog2(SRC_NUM);
    localparam int DW      = 32;
    localparam int AW      = 6;

    localparam logic [AW-1:0] A_MASK     = 6'h00;
    localparam logic [AW-1:0] A_DEFV     = 6'h01;
    localparam logic [AW-1:0] A_VECT     = 6'h02;
    localparam logic [AW-1:0] A_CTL_BASE = 6'h10;
    localparam logic [AW-1:0] A_ADR_BASE = 6'h20;

    typedef struct packed {
        logic             en;
        logic [SRC_W-1:0] src;
        logic [DW-1:0]    vaddr;
    } slot_cfg_t;

    function automatic logic [SRC_NUM-1:0] src_onehot(input logic [SRC_W-1:0] s);
        return SRC_NUM'(1) << s;
    endfunction

endpackage

// File: rtl/vpic_regs.sv
module vpic_regs
    import vpic_pkg::*;
#(
    parameter int NSLOT = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [AW-1:0]           addr,
    input  logic [DW-1:0]           wdata,
    input  logic [DW-1:0]           vect_i,
    output logic [DW-1:0]           rdata,
    output logic [SRC_NUM-1:0]      mask_o,
    output logic [DW-1:0]           defv_o,
    output slot_cfg_t [NSLOT-1:0]   cfg_o,
    output logic                    ack_o,
    output logic                    enter_o
);

    logic [SRC_NUM-1:0]    mask_q;
    logic [DW-1:0]         defv_q;
    slot_cfg_t [NSLOT-1:0] cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            defv_q <= '0;
            cfg_q  <= '0;
        end else if (wr_en) begin
            if (addr == A_MASK) mask_q <= wdata;
            if (addr == A_DEFV) defv_q <= wdata;
            for (int i = 0; i < NSLOT; i++) begin
                if (addr == A_CTL_BASE + AW'(i)) begin
                    cfg_q[i].en  <= wdata[SRC_W];
                    cfg_q[i].src <= wdata[SRC_W-1:0];
                end
                if (addr == A_ADR_BASE + AW'(i)) begin
                    cfg_q[i].vaddr <= wdata;
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == A_MASK) rdata = mask_q;
        if (addr == A_DEFV) rdata = defv_q;
        if (addr == A_VECT) rdata = vect_i;
        for (int i = 0; i < NSLOT; i++) begin
            if (addr == A_CTL_BASE + AW'(i)) rdata = DW'({cfg_q[i].en, cfg_q[i].src});
            if (addr == A_ADR_BASE + AW'(i)) rdata = cfg_q[i].vaddr;
        end
    end

    assign mask_o  = mask_q;
    assign defv_o  = defv_q;
    assign cfg_o   = cfg_q;
    assign ack_o   = wr_en && (addr == A_VECT);
    assign enter_o = rd_en && (addr == A_VECT);

    AST_CTL_READ_NARROW: assert property (@(posedge clk) disable iff (rst)
        (addr == A_CTL_BASE) |-> (rdata[DW-1:SRC_W+1] == '0)); // R3

endmodule

// File: rtl/vpic_arb.sv
module vpic_arb
    import vpic_pkg::*;
#(
    parameter int NSLOT = 16,
    parameter int LVL_W = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [SRC_NUM-1:0]    req_m,
    input  slot_cfg_t [NSLOT-1:0] cfg,
    input  logic [DW-1:0]         defv,
    output logic                  win_valid,
    output logic [LVL_W-1:0]      win_lvl,
    output logic [DW-1:0]         win_addr
);

    logic [NSLOT-1:0]   hit;
    logic [SRC_NUM-1:0] claim [NSLOT];
    logic [SRC_NUM-1:0] claimed;
    logic               orphan;

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        assign hit[g]   = cfg[g].en & req_m[cfg[g].src];
        assign claim[g] = cfg[g].en ? src_onehot(cfg[g].src) : '0;
    end

    always_comb begin
        claimed = '0;
        for (int i = 0; i < NSLOT; i++) claimed = claimed | claim[i];
    end

    assign orphan = |(req_m & ~claimed);

    always_comb begin
        win_valid = orphan;
        win_lvl   = LVL_W'(NSLOT);
        win_addr  = defv;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (hit[i]) begin
                win_valid = 1'b1;
                win_lvl   = LVL_W'(i);
                win_addr  = cfg[i].vaddr;
            end
        end
    end

    AST_WIN_IS_HIT: assert property (@(posedge clk) disable iff (rst)
        (win_valid && (win_lvl < LVL_W'(NSLOT))) |-> hit[win_lvl]); // R4
    AST_WIN_IS_LOWEST: assert property (@(posedge clk) disable iff (rst)
        win_valid |-> ((hit & ((NSLOT'(1) << win_lvl) - NSLOT'(1))) == '0)); // R5
    AST_ANY_REQ_WINS: assert property (@(posedge clk) disable iff (rst)
        (|req_m) |-> win_valid); // R6

endmodule

// File: rtl/vpic_stack.sv
module vpic_stack #(
    parameter int LEVELS = 17,
    parameter int LVL_W  = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [LVL_W-1:0] push_lvl,
    input  logic             pop,
    output logic [LVL_W-1:0] thr_q,
    output logic [LVL_W-1:0] thr_d
);

    logic [LEVELS-1:0] mask_q, mask_d, low_oh;

    function automatic logic [LVL_W-1:0] first_set(input logic [LEVELS-1:0] m);
        logic [LVL_W-1:0] r;
        r = LVL_W'(LEVELS);
        for (int i = LEVELS - 1; i >= 0; i--) if (m[i]) r = LVL_W'(i);
        return r;
    endfunction

    always_comb begin
        low_oh = '0;
        for (int i = LEVELS - 1; i >= 0; i--) begin
            if (mask_q[i]) low_oh = LEVELS'(1) << i;
        end
        mask_d = pop ? (mask_q & ~low_oh) : mask_q;
        if (push) mask_d = mask_d | (LEVELS'(1) << push_lvl);
    end

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '0;
        else     mask_q <= mask_d;
    end

    assign thr_q = first_set(mask_q);
    assign thr_d = first_set(mask_d);

    AST_PUSH_ABOVE: assert property (@(posedge clk) disable iff (rst)
        push |-> (push_lvl < thr_q)); // R9
    AST_POP_ONE: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && (mask_q != '0)) |=> ($countones(mask_q) == $countones($past(mask_q)) - 1)); // R10
    AST_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && (mask_q == '0)) |=> (mask_q == '0)); // R10

endmodule

// File: rtl/vpic_top.sv
module vpic_top
    import vpic_pkg::*;
#(
    parameter int NSLOT = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [SRC_NUM-1:0] req_i,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [AW-1:0]      addr,
    input  logic [DW-1:0]      wdata,
    output logic [DW-1:0]      rdata,
    output logic               irq_o
);

    localparam int LEVELS = NSLOT + 1;
    localparam int LVL_W  = $clog2(NSLOT + 2);

    logic [SRC_NUM-1:0]    mask, req_m;
    logic [DW-1:0]         defv, win_addr;
    slot_cfg_t [NSLOT-1:0] cfg;
    logic                  ack, enter, push, win_valid, eligible;
    logic [LVL_W-1:0]      win_lvl, thr_q, thr_d;

    logic                  irq_q;
    logic [DW-1:0]         vect_q;
    logic [LVL_W-1:0]      vlvl_q;

    vpic_regs #(.NSLOT(NSLOT)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .vect_i(vect_q), .rdata(rdata), .mask_o(mask),
        .defv_o(defv), .cfg_o(cfg), .ack_o(ack), .enter_o(enter)
    );

    assign req_m = req_i & mask;

    vpic_arb #(.NSLOT(NSLOT), .LVL_W(LVL_W)) u_arb (
        .clk(clk), .rst(rst), .req_m(req_m), .cfg(cfg), .defv(defv),
        .win_valid(win_valid), .win_lvl(win_lvl), .win_addr(win_addr)
    );

    assign push = enter && irq_q;

    vpic_stack #(.LEVELS(LEVELS), .LVL_W(LVL_W)) u_stack (
        .clk(clk), .rst(rst), .push(push), .push_lvl(vlvl_q), .pop(ack),
        .thr_q(thr_q), .thr_d(thr_d)
    );

    assign eligible = win_valid && (win_lvl < thr_d);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q  <= 1'b0;
            vect_q <= '0;
            vlvl_q <= '0;
        end else begin
            irq_q <= eligible;
            if (eligible) begin
                vect_q <= win_addr;
                vlvl_q <= win_lvl;
            end
        end
    end

    assign irq_o = irq_q;

    AST_IRQ_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> $past(|req_m)); // R2
    AST_NO_REQ_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
        (req_m == '0) |=> !irq_q); // R2
    AST_IRQ_BEATS_SERVICE: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> (vlvl_q < thr_q)); // R9
    AST_VECT_HELD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!win_valid) |=> $stable(vect_q)); // R9

endmodule

// File: tb/sim_vpic_top.sv
module sim_vpic_top;
    import vpic_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 16;
    localparam int WATCHDOG = 150000;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [SRC_NUM-1:0] req_i = '0;
    logic               wr_en = 1'b0;
    logic               rd_en = 1'b0;
    logic [AW-1:0]      addr = '0;
    logic [DW-1:0]      wdata = '0;
    logic [DW-1:0]      rdata;
    logic               irq_o;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vpic_top #(.NSLOT(NS)) u0 (
        .clk(clk), .rst(rst), .req_i(req_i), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    string tag = "R1";

    // behavioural model state
    logic [31:0] m_mask, m_defv, m_vect;
    logic [5:0]  m_ctl [NS];
    logic [31:0] m_adr [NS];
    int          m_stack [$];
    logic        m_irq;
    int          m_vlvl;

    task automatic model_reset();
        m_mask = 0; m_defv = 0; m_vect = 0; m_irq = 0; m_vlvl = 0;
        for (int i = 0; i < NS; i++) begin m_ctl[i] = 0; m_adr[i] = 0; end
        m_stack.delete();
    endtask

    task automatic model_win(output int lvl, output logic [31:0] a);
        logic [31:0] rm;
        rm = req_i & m_mask;
        lvl = -1; a = 0;
        for (int n = 0; n < 32; n++) begin
            if (rm[n]) begin
                bit owned = 0;
                for (int i = 0; i < NS; i++)
                    if (m_ctl[i][5] && m_ctl[i][4:0] == n[4:0]) owned = 1;
                if (!owned) begin lvl = NS; a = m_defv; end
            end
        end
        for (int i = NS - 1; i >= 0; i--) begin
            if (m_ctl[i][5] && rm[m_ctl[i][4:0]]) begin lvl = i; a = m_adr[i]; end
        end
    endtask

    function automatic logic [31:0] model_rd(input logic [5:0] a);
        if (a == A_MASK) return m_mask;
        if (a == A_DEFV) return m_defv;
        if (a == A_VECT) return m_vect;
        for (int i = 0; i < NS; i++) begin
            if (a == A_CTL_BASE + 6'(i)) return {26'b0, m_ctl[i]};
            if (a == A_ADR_BASE + 6'(i)) return m_adr[i];
        end
        return 0;
    endfunction

    task automatic model_edge();
        int lvl, thr;
        logic [31:0] wa;
        if (rst) begin model_reset(); return; end
        model_win(lvl, wa);
        if (wr_en && addr == A_VECT && m_stack.size() > 0) void'(m_stack.pop_back());
        if (rd_en && addr == A_VECT && m_irq) m_stack.push_back(m_vlvl);
        thr = (m_stack.size() == 0) ? NS + 1 : m_stack[$];
        m_irq = (lvl >= 0) && (lvl < thr);
        if (m_irq) begin m_vect = wa; m_vlvl = lvl; end
        if (wr_en) begin
            if (addr == A_MASK) m_mask = wdata;
            if (addr == A_DEFV) m_defv = wdata;
            for (int i = 0; i < NS; i++) begin
                if (addr == A_CTL_BASE + 6'(i)) m_ctl[i] = wdata[5:0];
                if (addr == A_ADR_BASE + 6'(i)) m_adr[i] = wdata;
            end
        end
    endtask

    task automatic compare();
        logic [31:0] er;
        checks++;
        if (irq_o !== m_irq) begin
            failures++;
            $display("FAIL %s irq_o actual=%0b expected=%0b", tag, irq_o, m_irq);
        end
        er = model_rd(addr);
        checks++;
        if (rdata !== er) begin
            failures++;
            $display("FAIL %s rdata[addr=%0h] actual=%0h expected=%0h", tag, addr, rdata, er);
        end
    endtask

    task automatic cyc(input logic w, input logic r, input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        compare();
        wr_en = w; rd_en = r; addr = a; wdata = d;
        @(posedge clk);
        model_edge();
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d); cyc(1, 0, a, d); endtask
    task automatic peek(input logic [5:0] a); cyc(0, 0, a, 0); endtask
    task automatic enter(); cyc(0, 1, A_VECT, 0); endtask
    task automatic ack(); cyc(1, 0, A_VECT, 32'hDEAD_BEEF); endtask
    task automatic idle(input int n); for (int k = 0; k < n; k++) peek(A_VECT); endtask

    task automatic set_req(input logic [31:0] r);
        @(negedge clk);
        compare();
        req_i = r; wr_en = 0; rd_en = 0; addr = A_VECT;
        @(posedge clk);
        model_edge();
    endtask

    initial begin
        model_reset();
        // R1: reset state
        tag = "R1";
        for (int k = 0; k < 3; k++) cyc(0, 0, 6'(k), 0);
        rst = 1'b0;
        peek(A_MASK); peek(A_DEFV); peek(A_VECT); peek(6'h10); peek(6'h2F);

        // R3: slot register read-back
        tag = "R3";
        wr(6'h10, 32'hFFFF_FF24);           // slot0: enable, source 4
        wr(6'h20, 32'h0000_1000);
        wr(6'h11, 32'h20 | 17);             // slot1: source 17
        wr(6'h21, 32'h0000_2000);
        wr(6'h12, 32'h20 | 17);             // slot2: also source 17
        wr(6'h22, 32'h0000_2222);
        wr(6'h13, 32'h20 | 6);              // slot3: source 6
        wr(6'h23, 32'h0000_3000);
        wr(A_DEFV, 32'h0000_DEF0);
        peek(6'h10); peek(6'h11); peek(6'h20); peek(6'h23); peek(A_DEFV);

        // R2: masked request ignored, then enabled
        tag = "R2";
        set_req(32'h0000_0010);
        idle(3);
        wr(A_MASK, (32'h1 << 4) | (32'h1 << 6) | (32'h1 << 9) | (32'h1 << 17));
        idle(3);
        set_req(0);
        idle(2);

        // R4: highest-priority slot's vector
        tag = "R4";
        set_req((32'h1 << 17) | (32'h1 << 6));
        idle(2);
        set_req((32'h1 << 17) | (32'h1 << 6) | (32'h1 << 4));
        idle(2);

        // R5: two slots on source 17, lower wins
        tag = "R5";
        set_req(32'h1 << 17);
        idle(2);

        // R7: disabling slot1 hands source 17 to slot2
        tag = "R7";
        wr(6'h11, 32'h0000_0011);
        idle(2);
        wr(6'h12, 32'h0000_0011);            // no slot for 17 now -> default
        idle(2);

        // R6: unclaimed source 9 gives default vector, below slot3
        tag = "R6";
        wr(6'h11, 32'h20 | 17);
        wr(6'h12, 32'h20 | 17);
        set_req(32'h1 << 9);
        idle(2);
        set_req((32'h1 << 9) | (32'h1 << 6));
        idle(2);
        set_req(0);
        idle(2);

        // R11: read with irq low enters nothing
        tag = "R11";
        enter();
        set_req(32'h1 << 6);
        idle(2);

        // R8: enter slot3, irq drops
        tag = "R8";
        enter();
        idle(2);

        // R9: lower and equal priority blocked, higher pre-empts
        tag = "R9";
        set_req((32'h1 << 6) | (32'h1 << 9));
        idle(2);
        set_req((32'h1 << 6) | (32'h1 << 9) | (32'h1 << 17));
        idle(2);
        enter();                              // enter slot1
        idle(2);
        set_req((32'h1 << 6) | (32'h1 << 9) | (32'h1 << 17) | (32'h1 << 4));
        idle(2);
        enter();                              // enter slot0
        idle(2);

        // R10: acknowledges pop one level at a time
        tag = "R10";
        set_req((32'h1 << 6) | (32'h1 << 9) | (32'h1 << 17));
        ack();                                // slot1 still active in service -> blocked
        idle(2);
        ack();                                // slot3 level remains; 17 outranks it
        idle(2);
        enter();
        set_req((32'h1 << 6) | (32'h1 << 9));
        ack();                                // back under slot3
        idle(2);
        ack();                                // nothing in service: slot3 request wins
        idle(2);
        ack();                                // ack with nothing entered
        idle(2);
        enter();
        set_req(32'h1 << 9);
        ack();
        idle(3);
        set_req(0);
        idle(2);

        @(negedge clk);
        compare();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired in %s", tag);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule